// File: doc/BRIEF.md
# Vector Operand Swizzle and Masked Writeback Path

This block is the operand side of a four-lane vector shader datapath. It holds the vector register file (output, input, temporary and uniform banks, each vector four 32-bit lanes) and presents two source operands to the arithmetic units. For each operand it reorders the lanes under a packed 2-bit-per-lane selector and can flip the sign bit of every lane. The first source index can be moved by an offset taken from one of two address lanes or from the loop counter. Results coming back from the arithmetic units are written under a 4-bit lane mask, so unselected lanes keep their contents.

An address-load operation turns lanes x and y of the fetched first operand, read as single-precision values, into saturated signed integers. These become the address lanes. A preload port fills any register slot and a peek port reads any slot, so that uniforms and inputs can be set up and results collected. Instruction decode and the floating-point units lie outside. Every control input is an already-decoded field.

Top module: `vsw_operand_path`

## Requirements
- R1: A synchronous active-low reset clears every register slot and both address lanes to zero, so both operands and the peek output read zero after it.
- R2: A vector packs lane x in bits 31:0, y in 63:32, z in 95:64 and w in 127:96. In an 8-bit swizzle selector, bits 7:6 name the source lane (0=x, 1=y, 2=z, 3=w) that feeds result lane x. Bits 5:4 feed y, bits 3:2 feed z and bits 1:0 feed w.
- R3: When an operand's negate input is high, bit 31 of each of its four swizzled lanes is inverted and the other bits pass unchanged. Each operand has its own selector and negate input.
- R4: With the write enable high, each result lane is stored only where its mask bit is set: bit 3 for x, bit 2 for y, bit 1 for z, bit 0 for w. Unselected lanes, and all lanes when the enable is low, keep their value.
- R5: Slot numbering is outputs 0–15, inputs 16–31, temporaries 32–47 and uniforms 48–143. Destination index d (5 bits) maps to slot d when d<16 and to slot d+16 otherwise. Source index s (7 bits) maps to slot s+16.
- R6: Offset select 0 adds zero, 1 adds address lane x, 2 adds address lane y and 3 adds the loop counter. The offset is added to the first source index only and never to the second.
- R7: An address load takes lanes x and y of the first operand after swizzle and negate. It truncates them toward zero and saturates them to the signed range of OFS_W bits. It writes x to address lane x when mask bit 3 is set and y to address lane y when mask bit 2 is set. Lanes not selected keep their value.
- R8: The offset first-source index wraps modulo 128, the size of the source index space, so it always reaches a valid slot.
- R9: The preload port writes a whole vector to any slot below 144. When a preload and a writeback hit the same slot in the same cycle, the writeback lanes win.
- R10: The peek port returns the vector in the addressed slot, and returns zero for any slot number of 144 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a_idx | input | 7 | First source index, before offset |
| src_b_idx | input | 7 | Second source index |
| ofs_sel | input | 2 | Offset source for the first index |
| swz_a | input | 8 | Swizzle selector, first operand |
| swz_b | input | 8 | Swizzle selector, second operand |
| neg_a | input | 1 | Negate first operand |
| neg_b | input | 1 | Negate second operand |
| loop_ctr | input | OFS_W | Loop counter offset value |
| opnd_a | output | 128 | First operand, swizzled and negated |
| opnd_b | output | 128 | Second operand, swizzled and negated |
| wb_en | input | 1 | Writeback enable |
| wb_idx | input | 5 | Destination index |
| wb_mask | input | 4 | Destination lane mask |
| wb_data | input | 128 | Result vector from the arithmetic units |
| aload_en | input | 1 | Address load from the first operand |
| pre_en | input | 1 | Preload enable |
| pre_slot | input | 8 | Preload slot number |
| pre_data | input | 128 | Preload vector |
| peek_slot | input | 8 | Peek slot number |
| peek_data | output | 128 | Vector held in the peek slot |

## Verification
The bench builds the block with OFS_W set to 6, so the address lanes saturate at +31 and −32. This keeps both saturation limits within reach of small float inputs such as ±1000.0. It also lets offsets push the first index past 127 or below 0 with modest values, which exercises the modulo-128 wrap. The register banks keep their default sizes, so the destination split between outputs and temporaries and the last uniform slot are covered as they would be in use.

// File: rtl/vsw_pkg.sv
// Shared types and helpers for the vector operand path.
// Assumes 32-bit single-precision lanes for the address conversion.
package vsw_pkg;

    typedef enum logic [1:0] {
        OFS_ZERO = 2'd0,
        OFS_AX   = 2'd1,
        OFS_AY   = 2'd2,
        OFS_LOOP = 2'd3
    } ofs_sel_e;

    // Truncate a single-precision value toward zero into a signed 32-bit integer.
    function automatic logic signed [31:0] f32_to_int(input logic [31:0] f);
        logic [7:0]  expo;
        logic [54:0] sh;
        logic [31:0] mag;
        expo = f[30:23];
        sh   = '0;
        if (expo < 8'd127) begin
            mag = '0;
        end else if (expo > 8'd157) begin
            mag = 32'h7FFF_FFFF;
        end else begin
            sh  = {31'b0, 1'b1, f[22:0]} << (expo - 8'd127);
            mag = sh[54:23];
        end
        return f[31] ? -$signed(mag) : $signed(mag);
    endfunction

endpackage

// File: rtl/vsw_swizzle.sv
// Lane permute and sign flip for one source operand.
// Assumes four lanes; each output lane picks its source lane from a
// 2-bit field of the selector, x taking the top field.
module vsw_swizzle #(
    parameter int LANE_W = 32,
    localparam int VEC_W = 4 * LANE_W
) (
    input  logic [VEC_W-1:0] vec_in,
    input  logic [7:0]       sel,
    input  logic             neg,
    output logic [VEC_W-1:0] vec_out
);

    localparam logic [LANE_W-1:0] SIGN_BIT = {1'b1, {(LANE_W-1){1'b0}}};

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [1:0] src_lane;
        // Pick source lane field for this output lane.
        assign src_lane = sel[7-2*l -: 2];
        // Route the chosen lane and apply the optional sign flip.
        assign vec_out[l*LANE_W +: LANE_W] =
            vec_in[src_lane*LANE_W +: LANE_W] ^ (neg ? SIGN_BIT : '0);
    end

endmodule

// File: rtl/vsw_regfile.sv
// Vector register file: three combinational read ports, one preload
// port writing whole vectors and one masked writeback port.
// Assumes the writeback slot is always in range; the preload slot
// is range checked. Writeback wins over preload on the same slot.
module vsw_regfile #(
    parameter int LANE_W = 32,
    parameter int SLOTS  = 144,
    localparam int VEC_W  = 4 * LANE_W,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en,
    input  logic [SLOT_W-1:0] wb_slot,
    input  logic [3:0]        wb_mask,
    input  logic [VEC_W-1:0]  wb_data,
    input  logic              pre_en,
    input  logic [SLOT_W-1:0] pre_slot,
    input  logic [VEC_W-1:0]  pre_data,
    input  logic [SLOT_W-1:0] ra_slot,
    output logic [VEC_W-1:0]  ra_data,
    input  logic [SLOT_W-1:0] rb_slot,
    output logic [VEC_W-1:0]  rb_data,
    input  logic [SLOT_W-1:0] rc_slot,
    output logic [VEC_W-1:0]  rc_data
);

    logic [VEC_W-1:0] mem [SLOTS];
    logic [VEC_W-1:0] merged;
    logic [VEC_W-1:0] wb_old;

    // Current contents of the writeback target.
    assign wb_old = mem[wb_slot];

    // Per-lane merge: mask bit 3 is lane x (lane 0).
    for (genvar l = 0; l < 4; l++) begin : g_merge
        assign merged[l*LANE_W +: LANE_W] =
            wb_mask[3-l] ? wb_data[l*LANE_W +: LANE_W] : wb_old[l*LANE_W +: LANE_W];
    end

    // Storage update: reset clear, preload, then writeback overriding it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (pre_en && (int'(pre_slot) < SLOTS)) begin
                mem[pre_slot] <= pre_data;
            end
            if (wb_en) begin
                mem[wb_slot] <= merged;
            end
        end
    end

    // Operand read ports.
    assign ra_data = mem[ra_slot];
    assign rb_data = mem[rb_slot];
    // Peek read port with out-of-range guard.
    assign rc_data = (int'(rc_slot) < SLOTS) ? mem[rc_slot] : '0;

endmodule

// File: rtl/vsw_addr.sv
// Address lanes x and y plus the offset selector.
// Assumes 32-bit single-precision source lanes; loads saturate to
// the signed OFS_W range and are gated per lane by the mask bits.
module vsw_addr
    import vsw_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [1:0]              load_mask,
    input  logic [31:0]             src_x,
    input  logic [31:0]             src_y,
    input  logic [OFS_W-1:0]        loop_ctr,
    input  logic [1:0]              sel,
    output logic signed [OFS_W-1:0] ofs,
    output logic signed [OFS_W-1:0] ax,
    output logic signed [OFS_W-1:0] ay
);

    localparam logic signed [31:0] MAXV = 32'sd2 ** (OFS_W - 1) - 32'sd1;
    localparam logic signed [31:0] MINV = -(32'sd2 ** (OFS_W - 1));

    logic signed [OFS_W-1:0] nx;
    logic signed [OFS_W-1:0] ny;

    // Clamp a converted integer into the address lane range.
    function automatic logic signed [OFS_W-1:0] clamp(input logic signed [31:0] v);
        logic signed [31:0] c;
        if (v > MAXV) begin
            c = MAXV;
        end else if (v < MINV) begin
            c = MINV;
        end else begin
            c = v;
        end
        return c[OFS_W-1:0];
    endfunction

    // Converted candidates for both address lanes.
    assign nx = clamp(f32_to_int(src_x));
    assign ny = clamp(f32_to_int(src_y));

    // Address lane update under reset and per-lane mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ax <= '0;
            ay <= '0;
        end else if (load_en) begin
            if (load_mask[1]) ax <= nx;
            if (load_mask[0]) ay <= ny;
        end
    end

    // Offset source selection.
    always_comb begin
        unique case (ofs_sel_e'(sel))
            OFS_ZERO: ofs = '0;
            OFS_AX:   ofs = ax;
            OFS_AY:   ofs = ay;
            OFS_LOOP: ofs = $signed(loop_ctr);
            default:  ofs = '0;
        endcase
    end

endmodule

// File: rtl/vsw_operand_path.sv
// Operand fetch and masked writeback for a four-lane vector datapath.
// Assumes decoded fields arrive stable before the clock edge; reads are
// combinational, writes and address loads happen on the rising edge.
// The source index space (inputs, temporaries, uniforms) must be a
// power of two so that the offset sum wraps by truncation.
module vsw_operand_path #(
    parameter int LANE_W = 32,
    parameter int N_OUT  = 16,
    parameter int N_IN   = 16,
    parameter int N_TMP  = 16,
    parameter int N_UNI  = 96,
    parameter int OFS_W  = 8,
    localparam int VEC_W  = 4 * LANE_W,
    localparam int SLOTS  = N_OUT + N_IN + N_TMP + N_UNI,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int SRC_W  = $clog2(N_IN + N_TMP + N_UNI),
    localparam int DST_W  = $clog2(N_OUT + N_TMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_a_idx,
    input  logic [SRC_W-1:0]  src_b_idx,
    input  logic [1:0]        ofs_sel,
    input  logic [7:0]        swz_a,
    input  logic [7:0]        swz_b,
    input  logic              neg_a,
    input  logic              neg_b,
    input  logic [OFS_W-1:0]  loop_ctr,
    output logic [VEC_W-1:0]  opnd_a,
    output logic [VEC_W-1:0]  opnd_b,
    input  logic              wb_en,
    input  logic [DST_W-1:0]  wb_idx,
    input  logic [3:0]        wb_mask,
    input  logic [VEC_W-1:0]  wb_data,
    input  logic              aload_en,
    input  logic              pre_en,
    input  logic [SLOT_W-1:0] pre_slot,
    input  logic [VEC_W-1:0]  pre_data,
    input  logic [SLOT_W-1:0] peek_slot,
    output logic [VEC_W-1:0]  peek_data
);

    logic signed [OFS_W-1:0] ofs;
    logic signed [OFS_W-1:0] ax;
    logic signed [OFS_W-1:0] ay;
    logic [SRC_W-1:0]  ofs_w;
    logic [SRC_W-1:0]  eff_a;
    logic [SLOT_W-1:0] slot_a;
    logic [SLOT_W-1:0] slot_b;
    logic [SLOT_W-1:0] wb_slot;
    logic [VEC_W-1:0]  raw_a;
    logic [VEC_W-1:0]  raw_b;

    // Sign-extend or trim the offset to the source index width.
    assign ofs_w = SRC_W'(ofs);
    // Offset first index; wraps modulo the source space.
    assign eff_a = src_a_idx + ofs_w;
    // Source indices start after the output bank.
    assign slot_a = SLOT_W'(eff_a) + SLOT_W'(N_OUT);
    assign slot_b = SLOT_W'(src_b_idx) + SLOT_W'(N_OUT);
    // Destination: low indices to outputs, the rest skip over the inputs.
    assign wb_slot = (int'(wb_idx) < N_OUT) ? SLOT_W'(wb_idx)
                                             : SLOT_W'(wb_idx) + SLOT_W'(N_IN);

    vsw_regfile #(
        .LANE_W(LANE_W),
        .SLOTS (SLOTS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_en   (wb_en),
        .wb_slot (wb_slot),
        .wb_mask (wb_mask),
        .wb_data (wb_data),
        .pre_en  (pre_en),
        .pre_slot(pre_slot),
        .pre_data(pre_data),
        .ra_slot (slot_a),
        .ra_data (raw_a),
        .rb_slot (slot_b),
        .rb_data (raw_b),
        .rc_slot (peek_slot),
        .rc_data (peek_data)
    );

    vsw_swizzle #(.LANE_W(LANE_W)) u_swz_a (
        .vec_in (raw_a),
        .sel    (swz_a),
        .neg    (neg_a),
        .vec_out(opnd_a)
    );

    vsw_swizzle #(.LANE_W(LANE_W)) u_swz_b (
        .vec_in (raw_b),
        .sel    (swz_b),
        .neg    (neg_b),
        .vec_out(opnd_b)
    );

    vsw_addr #(.OFS_W(OFS_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (aload_en),
        .load_mask(wb_mask[3:2]),
        .src_x    (opnd_a[31:0]),
        .src_y    (opnd_a[63:32]),
        .loop_ctr (loop_ctr),
        .sel      (ofs_sel),
        .ofs      (ofs),
        .ax       (ax),
        .ay       (ay)
    );

endmodule

// File: rtl/vsw_checker.sv
// Temporal checks on the operand path, bound into every instance.
module vsw_checker #(
    parameter int VEC_W  = 128,
    parameter int SRC_W  = 7,
    parameter int SLOT_W = 8,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  src_a_idx,
    input logic [SRC_W-1:0]  eff_a,
    input logic [1:0]        ofs_sel,
    input logic              aload_en,
    input logic              wb_en,
    input logic [3:0]        wb_mask,
    input logic [VEC_W-1:0]  wb_data,
    input logic [SLOT_W-1:0] wb_slot,
    input logic              pre_en,
    input logic [SLOT_W-1:0] peek_slot,
    input logic [VEC_W-1:0]  peek_data,
    input logic [OFS_W-1:0]  ax,
    input logic [OFS_W-1:0]  ay
);

    // R1: reset leaves both address lanes at zero.
    p_rst_ofs_r1: assert property (@(posedge clk)
        !rst_n |=> (ax == '0 && ay == '0));

    // R6: offset select zero leaves the first index untouched.
    p_sel_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_sel == 2'd0 |-> eff_a == src_a_idx);

    // R7: without an address load both lanes hold.
    p_aload_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !aload_en |=> ($stable(ax) && $stable(ay)));

    // R7: mask bit 3 clear keeps address lane x.
    p_aload_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aload_en && !wb_mask[3]) |=> $stable(ax));

    // R7: mask bit 2 clear keeps address lane y.
    p_aload_y_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aload_en && !wb_mask[2]) |=> $stable(ay));

    // R4: a full-mask writeback lands whole in the watched slot.
    p_wb_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_mask == 4'hF && peek_slot == wb_slot)
        |=> (peek_slot != $past(peek_slot) || peek_data == $past(wb_data)));

    // R4: an empty-mask writeback changes nothing in the watched slot.
    p_wb_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_mask == 4'h0 && !pre_en && peek_slot == wb_slot)
        |=> (peek_slot != $past(peek_slot) || peek_data == $past(peek_data)));

endmodule

bind vsw_operand_path vsw_checker #(
    .VEC_W (VEC_W),
    .SRC_W (SRC_W),
    .SLOT_W(SLOT_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_a_idx(src_a_idx),
    .eff_a    (eff_a),
    .ofs_sel  (ofs_sel),
    .aload_en (aload_en),
    .wb_en    (wb_en),
    .wb_mask  (wb_mask),
    .wb_data  (wb_data),
    .wb_slot  (wb_slot),
    .pre_en   (pre_en),
    .peek_slot(peek_slot),
    .peek_data(peek_data),
    .ax       (ax),
    .ay       (ay)
);

// File: tb/sim_vsw_operand_path.sv
module sim_vsw_operand_path;

    localparam int OFS_W = 6;
    localparam int SLOTS = 144;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   src_a_idx = '0, src_b_idx = '0;
    logic [1:0]   ofs_sel = '0;
    logic [7:0]   swz_a = 8'h1B, swz_b = 8'h1B;
    logic         neg_a = 1'b0, neg_b = 1'b0;
    logic [OFS_W-1:0] loop_ctr = '0;
    logic [127:0] opnd_a, opnd_b;
    logic         wb_en = 1'b0;
    logic [4:0]   wb_idx = '0;
    logic [3:0]   wb_mask = '0;
    logic [127:0] wb_data = '0;
    logic         aload_en = 1'b0;
    logic         pre_en = 1'b0;
    logic [7:0]   pre_slot = '0;
    logic [127:0] pre_data = '0;
    logic [7:0]   peek_slot = '0;
    logic [127:0] peek_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [127:0] shadow [SLOTS];

    always #2 clk = ~clk;

    vsw_operand_path #(.OFS_W(OFS_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .ofs_sel(ofs_sel),
        .swz_a(swz_a), .swz_b(swz_b), .neg_a(neg_a), .neg_b(neg_b),
        .loop_ctr(loop_ctr), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_mask(wb_mask), .wb_data(wb_data),
        .aload_en(aload_en), .pre_en(pre_en), .pre_slot(pre_slot),
        .pre_data(pre_data), .peek_slot(peek_slot), .peek_data(peek_data)
    );

    function automatic logic [127:0] v4(input logic [31:0] x, y, z, w);
        return {w, z, y, x};
    endfunction

    function automatic logic [127:0] pat(input int s);
        return v4(32'h1100_0000 + s, 32'h2200_0000 + s, 32'h3300_0000 + s, 32'h4400_0000 + s);
    endfunction

    // Expected operand built from the lane-selector rule.
    function automatic logic [127:0] expect_op(input logic [127:0] v, input logic [7:0] s, input logic n);
        logic [31:0] ln [4];
        logic [31:0] o [4];
        for (int k = 0; k < 4; k++) ln[k] = v[32*k +: 32];
        o[0] = ln[s[7:6]];
        o[1] = ln[s[5:4]];
        o[2] = ln[s[3:2]];
        o[3] = ln[s[1:0]];
        if (n) for (int k = 0; k < 4; k++) o[k][31] = ~o[k][31];
        return v4(o[0], o[1], o[2], o[3]);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input int s, input logic [127:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_slot = 8'(s); pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
        shadow[s] = d;
    endtask

    task automatic writeback(input int d, input logic [3:0] m, input logic [127:0] r);
        int s;
        s = (d < 16) ? d : d + 16;
        @(negedge clk);
        wb_en = 1'b1; wb_idx = 5'(d); wb_mask = m; wb_data = r;
        @(negedge clk);
        wb_en = 1'b0;
        for (int k = 0; k < 4; k++)
            if (m[3-k]) shadow[s][32*k +: 32] = r[32*k +: 32];
    endtask

    task automatic aload(input int src, input logic [3:0] m, input logic n);
        @(negedge clk);
        ofs_sel = 2'd0; src_a_idx = 7'(src); swz_a = 8'h1B; neg_a = n;
        wb_mask = m; aload_en = 1'b1;
        @(negedge clk);
        aload_en = 1'b0; neg_a = 1'b0;
    endtask

    // Read operand A through an offset and compare with the expected slot.
    task automatic read_a(input string req, input logic [1:0] os, input int idx, input int exp_slot);
        @(negedge clk);
        ofs_sel = os; src_a_idx = 7'(idx); swz_a = 8'h1B; neg_a = 1'b0;
        #1;
        check(req, opnd_a, shadow[exp_slot]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        peek_slot = 8'd0;   #1; check("R1 peek slot0", peek_data, '0);
        peek_slot = 8'd143; #1; check("R1 peek slot143", peek_data, '0);
        src_a_idx = 7'd5; src_b_idx = 7'd100; #1;
        check("R1 opnd_a", opnd_a, '0);
        check("R1 opnd_b", opnd_b, '0);
    endtask

    task automatic t_fill;
        for (int s = 0; s < SLOTS; s++) preload(s, pat(s));
        @(negedge clk);
        peek_slot = 8'd77; #1; check("R9 preload whole vector", peek_data, pat(77));
        peek_slot = 8'd200; #1; check("R10 peek out of range", peek_data, '0);
    endtask

    task automatic t_swizzle;
        logic [7:0] sels [4] = '{8'h1B, 8'hE4, 8'h55, 8'h9C};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ofs_sel = 2'd0; src_a_idx = 7'd3; swz_a = sels[i]; neg_a = 1'b0;
            src_b_idx = 7'd40; swz_b = sels[3-i]; neg_b = 1'b0;
            #1;
            check("R2 swizzle opnd_a", opnd_a, expect_op(shadow[19], sels[i], 1'b0));
            check("R5 R2 swizzle opnd_b uniform", opnd_b, expect_op(shadow[56], sels[3-i], 1'b0));
        end
    endtask

    task automatic t_negate;
        @(negedge clk);
        src_a_idx = 7'd3; swz_a = 8'hE4; neg_a = 1'b1;
        src_b_idx = 7'd3; swz_b = 8'hE4; neg_b = 1'b0;
        #1;
        check("R3 negate a", opnd_a, expect_op(shadow[19], 8'hE4, 1'b1));
        check("R3 b independent", opnd_b, expect_op(shadow[19], 8'hE4, 1'b0));
        neg_a = 1'b0; neg_b = 1'b1; #1;
        check("R3 negate b", opnd_b, expect_op(shadow[19], 8'hE4, 1'b1));
        neg_b = 1'b0;
    endtask

    task automatic t_writeback;
        logic [127:0] r = v4(32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003, 32'hAAAA_0004);
        writeback(5, 4'hF, r);
        @(negedge clk); peek_slot = 8'd5; #1; check("R4 R5 full write output", peek_data, r);
        writeback(20, 4'b1010, ~r);
        @(negedge clk); peek_slot = 8'd36; #1; check("R4 R5 masked write temp", peek_data, shadow[36]);
        check("R5 keep lane y", {96'b0, peek_data[63:32]}, {96'b0, pat(36)[63:32]});
        @(negedge clk); ofs_sel = 2'd0; src_a_idx = 7'd20; swz_a = 8'h1B; #1;
        check("R5 temp read via source", opnd_a, shadow[36]);
        @(negedge clk);
        wb_en = 1'b0; wb_idx = 5'd5; wb_mask = 4'hF; wb_data = '1;
        @(negedge clk); peek_slot = 8'd5; #1; check("R4 enable low no write", peek_data, shadow[5]);
        writeback(31, 4'h0, '1);
        @(negedge clk); peek_slot = 8'd47; #1; check("R4 empty mask", peek_data, shadow[47]);
        peek_slot = 8'd31; #1; check("R5 index 31 not in inputs", peek_data, shadow[31]);
    endtask

    task automatic t_priority;
        @(negedge clk);
        pre_en = 1'b1; pre_slot = 8'd9; pre_data = '0;
        wb_en = 1'b1; wb_idx = 5'd9; wb_mask = 4'hF; wb_data = pat(999);
        @(negedge clk);
        pre_en = 1'b0; wb_en = 1'b0;
        shadow[9] = pat(999);
        peek_slot = 8'd9; #1; check("R9 writeback over preload", peek_data, pat(999));
    endtask

    task automatic t_address;
        preload(16, v4(32'h40B8_0000, 32'hC060_0000, 32'h0, 32'h0)); // 5.75, -3.5
        aload(0, 4'b1100, 1'b0);   // ax=5 ay=-3
        read_a("R6 R7 lane x offset", 2'd1, 2, 23);
        read_a("R6 R7 R8 lane y offset wraps", 2'd2, 2, 143);
        @(negedge clk); loop_ctr = 6'd9;
        read_a("R6 loop counter offset", 2'd3, 1, 26);
        read_a("R6 select zero", 2'd0, 4, 20);
        @(negedge clk); ofs_sel = 2'd1; src_b_idx = 7'd2; swz_b = 8'h1B; neg_b = 1'b0; #1;
        check("R6 no offset on second source", opnd_b, shadow[18]);
        aload(0, 4'b1000, 1'b1);   // ax=-5, ay stays -3
        read_a("R7 negated load x", 2'd1, 10, 21);
        read_a("R7 masked y kept", 2'd2, 10, 23);
        aload(0, 4'b0000, 1'b0);   // nothing changes
        read_a("R7 empty mask keeps x", 2'd1, 10, 21);
        preload(17, v4(32'h447A_0000, 32'hC47A_0000, 32'h0, 32'h0)); // 1000, -1000
        aload(1, 4'b1100, 1'b0);   // ax=31 ay=-32
        read_a("R7 positive saturation", 2'd1, 0, 47);
        read_a("R7 negative saturation", 2'd2, 40, 24);
        read_a("R8 wrap past top", 2'd1, 120, 39);
        preload(18, v4(32'h3F00_0000, 32'hBF40_0000, 32'h0, 32'h0)); // 0.5, -0.75
        aload(2, 4'b1100, 1'b0);   // both zero
        read_a("R7 truncate to zero x", 2'd1, 9, 25);
        read_a("R7 truncate to zero y", 2'd2, 9, 25);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < SLOTS; s++) shadow[s] = '0;
        peek_slot = 8'd56; #1; check("R1 second reset clears", peek_data, '0);
    endtask

    initial begin
        for (int s = 0; s < SLOTS; s++) shadow[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_fill;
        t_swizzle;
        t_negate;
        t_writeback;
        t_priority;
        t_address;
        t_reset_again;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule